// File: doc/BRIEF.md
# Per-Thread Store Buffer with Load Forwarding

This block keeps the stores that a four-thread, single-issue core has already executed but that the shared next-level cache has not yet accepted. Each hardware thread owns a private in-order queue of eight entries. A queued store leaves its queue only when the next-level cache acknowledges it. In the cycle after that acknowledgement the block emits an update toward the local write-through data cache. As a result, no other thread can observe a store before the shared cache holds it.

Each load is looked up in its own thread's queue only, after address translation, using the physical doubleword address and the load's byte lanes. If the youngest overlapping store covers every byte the load needs, its data is forwarded. If it covers only some of those bytes, the load is told to stall. With no overlap, the load proceeds to the cache.

A round-robin drain arbiter chooses which thread's oldest store is offered to the crossbar side. It holds that offer stable until it is acknowledged. A per-thread full flag stalls only the thread that owns a full queue.

Top module: `sb_store_buffer`

## Requirements
- R1: After synchronous reset every queue is empty: `thr_full` is 0, `drn_valid` is 0, and `ld_rsp_valid` and `l1_wr_valid` are 0.
- R2: A store with `st_valid` high is appended to the queue of thread `st_tid` at the clock edge, unless that queue already holds 8 entries, in which case the store is dropped. `thr_full[t]` is 1 exactly when queue t holds 8 entries. Only `st_addr[PA_W-1:3]` is kept, and the byte lanes come from `st_mask`.
- R3: Each queue drains strictly oldest first. While `drn_valid` is high and `drn_ack` is low, the offered thread, address, mask and data stay unchanged. The offered entry is freed at the edge where `drn_valid` and `drn_ack` are both high.
- R4: When no offer is pending, the offered thread is the first non-empty thread found scanning upward, with wrap-around, from one past the last acknowledged thread. After reset that scan starts at thread 0.
- R5: One cycle after `ld_valid`, `ld_rsp_valid` is high. If the youngest overlapping store covers all load bytes, `ld_rsp_hit` is 1 and `ld_rsp_data` holds that store's data with non-load byte lanes zero.
- R6: When several stores of the thread overlap the load, only the youngest overlapping one decides the result.
- R7: When the youngest overlapping store covers only part of the load bytes, `ld_rsp_stall` is 1 and `ld_rsp_hit` is 0.
- R8: Stores queued for other threads never forward to a load, nor make it stall.
- R9: Load lanes use little-endian order, with lane i equal to data bits [8i+7:8i]. `ld_size` 0/1/2/3 means 1/2/4/8 bytes starting at lane `ld_addr[2:0]`, and loads are naturally aligned. Matching compares `ld_addr[PA_W-1:3]`.
- R10: `l1_wr_valid` pulses in the cycle after each drain handshake, carrying that store's thread, address, mask and data, and is low at all other times.
- R11: The lookup, the full flag and the accept decision use the queue contents before the current edge. A store enqueued in the same cycle as an acknowledgement for its own thread is accepted if the queue was not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store enqueue strobe |
| st_tid | input | 2 | Thread of the store |
| st_addr | input | 40 | Physical store address |
| st_mask | input | 8 | Store byte lanes |
| st_data | input | 64 | Store data, lane aligned |
| ld_valid | input | 1 | Load lookup strobe |
| ld_tid | input | 2 | Thread of the load |
| ld_addr | input | 40 | Physical load address |
| ld_size | input | 2 | Load size code |
| ld_rsp_valid | output | 1 | Lookup result valid |
| ld_rsp_hit | output | 1 | Full forward available |
| ld_rsp_stall | output | 1 | Partial overlap, load must wait |
| ld_rsp_data | output | 64 | Forwarded data |
| drn_valid | output | 1 | Drain offer valid |
| drn_tid | output | 2 | Thread of offered store |
| drn_addr | output | 40 | Doubleword address of offered store |
| drn_mask | output | 8 | Byte lanes of offered store |
| drn_data | output | 64 | Data of offered store |
| drn_ack | input | 1 | Next-level cache accepted the offer |
| l1_wr_valid | output | 1 | Local cache update strobe |
| l1_wr_tid | output | 2 | Thread of the update |
| l1_wr_addr | output | 40 | Address of the update |
| l1_wr_mask | output | 8 | Byte lanes of the update |
| l1_wr_data | output | 64 | Data of the update |
| thr_full | output | 4 | Per-thread queue full |

## Verification
An enqueue, a drain acknowledgement and a load lookup can all hit the same thread in one cycle. The enqueue and the acknowledgement then change the queue depth in opposite directions, and the lookup must still see the entry being freed. A pseudo-random phase drives all three at once across a small set of addresses with an irregular acknowledge pattern. A reference model in the bench decides acceptance from the pre-edge depth, then pops and pushes, and predicts every lookup result, drain offer and cache update. Directed sequences before it pin down youngest-wins, partial-overlap stalls, cross-thread isolation and the dropped store on a full queue.

// File: rtl/sb_pkg.sv
package sb_pkg;

    parameter int PA_W   = 40;
    parameter int DW     = 64;
    localparam int BYTES  = DW / 8;
    localparam int OFF_W  = $clog2(BYTES);
    localparam int LINE_W = PA_W - OFF_W;

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic [BYTES-1:0]  mask;
        logic [DW-1:0]     data;
    } sb_entry_t;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } ld_size_e;

    typedef enum logic [1:0] {
        LK_MISS  = 2'd0,
        LK_HIT   = 2'd1,
        LK_STALL = 2'd2
    } lk_res_e;

    // Byte lanes touched by an aligned access of 2**sz bytes at offset off.
    function automatic logic [BYTES-1:0] lane_mask(logic [OFF_W-1:0] off, logic [1:0] sz);
        logic [2*BYTES-1:0] w;
        int unsigned n;
        n = 1 << sz;
        w = ((2*BYTES)'(1) << n) - (2*BYTES)'(1);
        w = w << off;
        return w[BYTES-1:0];
    endfunction

    function automatic logic [DW-1:0] lane_expand(logic [BYTES-1:0] m);
        logic [DW-1:0] r;
        for (int i = 0; i < BYTES; i++) r[8*i +: 8] = {8{m[i]}};
        return r;
    endfunction

endpackage

// File: rtl/sb_thread_fifo.sv
module sb_thread_fifo
    import sb_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  sb_entry_t         push_ent,
    input  logic              pop,
    input  logic [LINE_W-1:0] lk_line,
    input  logic [BYTES-1:0]  lk_mask,
    output logic              full,
    output logic              empty,
    output sb_entry_t         head_ent,
    output logic              lk_ovl,
    output sb_entry_t         lk_ent
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    sb_entry_t        mem [DEPTH];
    logic [PTR_W-1:0] head;
    logic [PTR_W-1:0] tail;
    logic [CNT_W-1:0] count;
    logic             push_ok;
    logic             pop_ok;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head_ent = mem[head];

    function automatic logic [PTR_W-1:0] nxt(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push_ok) tail <= nxt(tail);
            if (pop_ok)  head <= nxt(head);
            count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[tail] <= push_ent;
    end

    // Scan oldest to youngest; the last overlapping entry found is the youngest.
    always_comb begin
        lk_ovl = 1'b0;
        lk_ent = '0;
        for (int a = 0; a < DEPTH; a++) begin
            int idx;
            idx = (int'(head) + a) % DEPTH;
            if (a < int'(count) && mem[idx].line == lk_line &&
                (mem[idx].mask & lk_mask) != '0) begin
                lk_ovl = 1'b1;
                lk_ent = mem[idx];
            end
        end
    end

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty) else $error("pop on empty queue"); // R3

    AST_FULL_KEEPS: assert property (@(posedge clk) disable iff (rst)
        full && !pop |=> full) else $error("full queue lost an entry"); // R2

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        push && full && !pop |=> $stable(tail)) else $error("store accepted while full"); // R2

endmodule

// File: rtl/sb_drain_arb.sv
module sb_drain_arb #(
    parameter int NTHR = 4,
    localparam int TID_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NTHR-1:0]  pending,
    input  logic             ack,
    output logic             vld,
    output logic [TID_W-1:0] tid
);

    logic [TID_W-1:0] rr_ptr;
    logic             lock_vld;
    logic [TID_W-1:0] lock_tid;
    logic             found;
    logic [TID_W-1:0] pick;

    always_comb begin
        found = 1'b0;
        pick  = rr_ptr;
        for (int k = 0; k < NTHR; k++) begin
            int t;
            t = (int'(rr_ptr) + k) % NTHR;
            if (!found && pending[t]) begin
                found = 1'b1;
                pick  = TID_W'(t);
            end
        end
    end

    assign tid = lock_vld ? lock_tid : pick;
    assign vld = lock_vld | found;

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_ptr   <= '0;
            lock_vld <= 1'b0;
            lock_tid <= '0;
        end else if (vld && ack) begin
            lock_vld <= 1'b0;
            rr_ptr   <= (tid == TID_W'(NTHR - 1)) ? '0 : tid + 1'b1;
        end else if (vld) begin
            lock_vld <= 1'b1;
            lock_tid <= tid;
        end
    end

    AST_LOCK_PENDING: assert property (@(posedge clk) disable iff (rst)
        lock_vld |-> pending[lock_tid]) else $error("held offer has no store"); // R3

    AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (rst)
        vld && !ack |=> vld && $stable(tid)) else $error("offer thread moved"); // R3

endmodule

// File: rtl/sb_store_buffer.sv
module sb_store_buffer
    import sb_pkg::*;
#(
    parameter int NTHR  = 4,
    parameter int DEPTH = 8,
    localparam int TID_W = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             st_valid,
    input  logic [TID_W-1:0] st_tid,
    input  logic [PA_W-1:0]  st_addr,
    input  logic [BYTES-1:0] st_mask,
    input  logic [DW-1:0]    st_data,
    input  logic             ld_valid,
    input  logic [TID_W-1:0] ld_tid,
    input  logic [PA_W-1:0]  ld_addr,
    input  logic [1:0]       ld_size,
    output logic             ld_rsp_valid,
    output logic             ld_rsp_hit,
    output logic             ld_rsp_stall,
    output logic [DW-1:0]    ld_rsp_data,
    output logic             drn_valid,
    output logic [TID_W-1:0] drn_tid,
    output logic [PA_W-1:0]  drn_addr,
    output logic [BYTES-1:0] drn_mask,
    output logic [DW-1:0]    drn_data,
    input  logic             drn_ack,
    output logic             l1_wr_valid,
    output logic [TID_W-1:0] l1_wr_tid,
    output logic [PA_W-1:0]  l1_wr_addr,
    output logic [BYTES-1:0] l1_wr_mask,
    output logic [DW-1:0]    l1_wr_data,
    output logic [NTHR-1:0]  thr_full
);

    sb_entry_t         st_ent;
    sb_entry_t         head_ent [NTHR];
    sb_entry_t         lk_ent   [NTHR];
    logic [NTHR-1:0]   lk_ovl;
    logic [NTHR-1:0]   thr_empty;
    logic [LINE_W-1:0] ld_line;
    logic [BYTES-1:0]  ld_mask;
    logic              drn_fire;
    sb_entry_t         drn_ent;

    assign st_ent   = '{line: st_addr[PA_W-1:OFF_W], mask: st_mask, data: st_data};
    assign ld_line  = ld_addr[PA_W-1:OFF_W];
    assign ld_mask  = lane_mask(ld_addr[OFF_W-1:0], ld_size);
    assign drn_fire = drn_valid && drn_ack;

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        sb_thread_fifo #(.DEPTH(DEPTH)) u_fifo (
            .clk      (clk),
            .rst      (rst),
            .push     (st_valid && st_tid == TID_W'(t)),
            .push_ent (st_ent),
            .pop      (drn_fire && drn_tid == TID_W'(t)),
            .lk_line  (ld_line),
            .lk_mask  (ld_mask),
            .full     (thr_full[t]),
            .empty    (thr_empty[t]),
            .head_ent (head_ent[t]),
            .lk_ovl   (lk_ovl[t]),
            .lk_ent   (lk_ent[t])
        );
    end

    sb_drain_arb #(.NTHR(NTHR)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .pending (~thr_empty),
        .ack     (drn_ack),
        .vld     (drn_valid),
        .tid     (drn_tid)
    );

    assign drn_ent  = head_ent[drn_tid];
    assign drn_addr = {drn_ent.line, {OFF_W{1'b0}}};
    assign drn_mask = drn_ent.mask;
    assign drn_data = drn_ent.data;

    // Lookup classification, registered for the following cycle.
    lk_res_e   lk_res;
    lk_res_e   rsp_res;
    sb_entry_t sel;

    always_comb begin
        sel = lk_ent[ld_tid];
        if (!lk_ovl[ld_tid])                      lk_res = LK_MISS;
        else if ((sel.mask & ld_mask) == ld_mask) lk_res = LK_HIT;
        else                                      lk_res = LK_STALL;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_rsp_valid <= 1'b0;
            rsp_res      <= LK_MISS;
            ld_rsp_data  <= '0;
        end else begin
            ld_rsp_valid <= ld_valid;
            rsp_res      <= ld_valid ? lk_res : LK_MISS;
            ld_rsp_data  <= (ld_valid && lk_res == LK_HIT) ?
                            (sel.data & lane_expand(ld_mask)) : '0;
        end
    end

    assign ld_rsp_hit   = (rsp_res == LK_HIT);
    assign ld_rsp_stall = (rsp_res == LK_STALL);

    always_ff @(posedge clk) begin
        if (rst) begin
            l1_wr_valid <= 1'b0;
            l1_wr_tid   <= '0;
            l1_wr_addr  <= '0;
            l1_wr_mask  <= '0;
            l1_wr_data  <= '0;
        end else begin
            l1_wr_valid <= drn_fire;
            if (drn_fire) begin
                l1_wr_tid  <= drn_tid;
                l1_wr_addr <= drn_addr;
                l1_wr_mask <= drn_mask;
                l1_wr_data <= drn_data;
            end
        end
    end

    AST_DRN_STABLE: assert property (@(posedge clk) disable iff (rst)
        drn_valid && !drn_ack |=> drn_valid && $stable(drn_addr) &&
        $stable(drn_mask) && $stable(drn_data)) else $error("drain payload changed"); // R3

    AST_L1_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        l1_wr_valid |-> $past(drn_valid && drn_ack)) else $error("cache update without handshake"); // R10

    AST_RSP_NEEDS_LOAD: assert property (@(posedge clk) disable iff (rst)
        (ld_rsp_hit || ld_rsp_stall) |-> ld_rsp_valid) else $error("result without load"); // R5

    AST_OWN_THREAD: assert property (@(posedge clk) disable iff (rst)
        ld_valid && thr_empty[ld_tid] |=> !ld_rsp_hit && !ld_rsp_stall)
        else $error("forward from empty own queue"); // R8

endmodule

// File: tb/test_sb_store_buffer.sv
`timescale 1ns/1ps
module test_sb_store_buffer;
    import sb_pkg::*;

    localparam int NT = 4;
    localparam int DP = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        st_valid = 0;
    logic [1:0]  st_tid = 0;
    logic [39:0] st_addr = 0;
    logic [7:0]  st_mask = 0;
    logic [63:0] st_data = 0;
    logic        ld_valid = 0;
    logic [1:0]  ld_tid = 0;
    logic [39:0] ld_addr = 0;
    logic [1:0]  ld_size = 0;
    logic        ld_rsp_valid, ld_rsp_hit, ld_rsp_stall;
    logic [63:0] ld_rsp_data;
    logic        drn_valid;
    logic [1:0]  drn_tid;
    logic [39:0] drn_addr;
    logic [7:0]  drn_mask;
    logic [63:0] drn_data;
    logic        drn_ack = 0;
    logic        l1_wr_valid;
    logic [1:0]  l1_wr_tid;
    logic [39:0] l1_wr_addr;
    logic [7:0]  l1_wr_mask;
    logic [63:0] l1_wr_data;
    logic [3:0]  thr_full;

    always #2 clk = ~clk;

    sb_store_buffer #(.NTHR(NT), .DEPTH(DP)) i_sb_store_buffer (
        .clk, .rst, .st_valid, .st_tid, .st_addr, .st_mask, .st_data,
        .ld_valid, .ld_tid, .ld_addr, .ld_size,
        .ld_rsp_valid, .ld_rsp_hit, .ld_rsp_stall, .ld_rsp_data,
        .drn_valid, .drn_tid, .drn_addr, .drn_mask, .drn_data, .drn_ack,
        .l1_wr_valid, .l1_wr_tid, .l1_wr_addr, .l1_wr_mask, .l1_wr_data,
        .thr_full
    );

    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- reference model (scoreboard) ----------------
    sb_entry_t   mq [NT][$];
    int          m_rr = 0;
    bit          m_lock = 0;
    int          m_lock_tid = 0;
    bit          p_ld = 0;
    int          p_res = 0;
    logic [63:0] p_data = 0;
    string       p_tag = "R5";
    string       ld_tag = "R5";
    string       dr_tag = "R3";
    bit          p_l1 = 0;
    sb_entry_t   p_l1_ent;
    int          p_l1_tid = 0;

    function automatic logic [7:0] ref_lanes(logic [2:0] off, logic [1:0] sz);
        logic [7:0] m;
        int n;
        m = 0;
        n = 1 << sz;
        for (int i = 0; i < n; i++) if (int'(off) + i < 8) m[int'(off) + i] = 1'b1;
        return m;
    endfunction

    // 0 miss, 1 hit, 2 stall
    task automatic ref_lookup(int t, logic [39:0] a, logic [1:0] sz, output int res, output logic [63:0] d);
        logic [7:0] lm;
        lm  = ref_lanes(a[2:0], sz);
        res = 0;
        d   = 0;
        foreach (mq[t][i]) begin
            if (mq[t][i].line == a[39:3] && (mq[t][i].mask & lm) != 0) begin
                if ((mq[t][i].mask & lm) == lm) begin
                    res = 1;
                    d = 0;
                    for (int b = 0; b < 8; b++) if (lm[b]) d[8*b +: 8] = mq[t][i].data[8*b +: 8];
                end else begin
                    res = 2;
                    d = 0;
                end
            end
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            for (int t = 0; t < NT; t++) mq[t].delete();
            m_rr = 0; m_lock = 0; m_lock_tid = 0; p_ld = 0; p_l1 = 0;
        end else begin
            int  exp_tid;
            bit  exp_vld;
            bit  acc;
            int  r;
            logic [63:0] d;
            // lookup result of the previous cycle
            chk(ld_rsp_valid == p_ld, p_tag, "rsp_valid", 64'(ld_rsp_valid), 64'(p_ld));
            if (p_ld) begin
                chk(ld_rsp_hit == (p_res == 1), p_tag, "rsp_hit", 64'(ld_rsp_hit), 64'(p_res == 1));
                chk(ld_rsp_stall == (p_res == 2), p_tag, "rsp_stall", 64'(ld_rsp_stall), 64'(p_res == 2));
                if (p_res == 1) chk(ld_rsp_data == p_data, p_tag, "rsp_data", ld_rsp_data, p_data);
            end
            // local cache update of the previous cycle
            chk(l1_wr_valid == p_l1, "R10", "l1_valid", 64'(l1_wr_valid), 64'(p_l1));
            if (p_l1) begin
                chk(l1_wr_tid == 2'(p_l1_tid), "R10", "l1_tid", 64'(l1_wr_tid), 64'(p_l1_tid));
                chk(l1_wr_addr == {p_l1_ent.line, 3'b000}, "R10", "l1_addr", 64'(l1_wr_addr), 64'({p_l1_ent.line, 3'b000}));
                chk(l1_wr_mask == p_l1_ent.mask, "R10", "l1_mask", 64'(l1_wr_mask), 64'(p_l1_ent.mask));
                chk(l1_wr_data == p_l1_ent.data, "R10", "l1_data", l1_wr_data, p_l1_ent.data);
            end
            // drain offer
            exp_vld = m_lock;
            exp_tid = m_lock_tid;
            if (!m_lock) begin
                for (int k = 0; k < NT; k++) begin
                    int t;
                    t = (m_rr + k) % NT;
                    if (!exp_vld && mq[t].size() > 0) begin exp_vld = 1; exp_tid = t; end
                end
            end
            chk(drn_valid == exp_vld, dr_tag, "drn_valid", 64'(drn_valid), 64'(exp_vld));
            if (exp_vld) begin
                chk(drn_tid == 2'(exp_tid), m_lock ? "R3" : "R4", "drn_tid", 64'(drn_tid), 64'(exp_tid));
                chk(drn_addr == {mq[exp_tid][0].line, 3'b000}, "R3", "drn_addr", 64'(drn_addr), 64'({mq[exp_tid][0].line, 3'b000}));
                chk(drn_mask == mq[exp_tid][0].mask, "R3", "drn_mask", 64'(drn_mask), 64'(mq[exp_tid][0].mask));
                chk(drn_data == mq[exp_tid][0].data, "R3", "drn_data", drn_data, mq[exp_tid][0].data);
            end
            for (int t = 0; t < NT; t++)
                chk(thr_full[t] == (mq[t].size() == DP), "R2", "thr_full", 64'(thr_full[t]), 64'(mq[t].size() == DP));
            // predict next cycle from pre-edge state (R11)
            p_ld = ld_valid;
            p_tag = ld_tag;
            if (ld_valid) begin
                ref_lookup(int'(ld_tid), ld_addr, ld_size, r, d);
                p_res = r;
                p_data = d;
            end
            acc = st_valid && (mq[st_tid].size() < DP);
            p_l1 = exp_vld && drn_ack;
            if (p_l1) begin
                p_l1_ent = mq[exp_tid].pop_front();
                p_l1_tid = exp_tid;
                m_rr = (exp_tid + 1) % NT;
                m_lock = 0;
            end else begin
                m_lock = exp_vld;
                m_lock_tid = exp_tid;
            end
            if (acc) mq[st_tid].push_back('{line: st_addr[39:3], mask: st_mask, data: st_data});
        end
    end

    // ---------------- driver ----------------
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_store(int t, logic [39:0] a, logic [7:0] m, logic [63:0] d);
        st_valid = 1; st_tid = 2'(t); st_addr = a; st_mask = m; st_data = d;
        tick();
        st_valid = 0;
    endtask

    task automatic do_load(int t, logic [39:0] a, logic [1:0] sz, string tag);
        ld_valid = 1; ld_tid = 2'(t); ld_addr = a; ld_size = sz; ld_tag = tag;
        tick();
        ld_valid = 0;
    endtask

    initial begin
        logic [31:0] lf;
        repeat (3) tick();
        rst = 0;
        @(negedge clk);
        chk(thr_full == 0, "R1", "full after reset", 64'(thr_full), 0);
        chk(drn_valid == 0, "R1", "drn after reset", 64'(drn_valid), 0);
        chk(ld_rsp_valid == 0, "R1", "rsp after reset", 64'(ld_rsp_valid), 0);
        chk(l1_wr_valid == 0, "R1", "l1 after reset", 64'(l1_wr_valid), 0);
        tick();
        // thread 0 stores, no acknowledgements yet
        do_store(0, 40'h1000, 8'hFF, 64'h1111_2222_3333_4444);
        do_store(0, 40'h1000, 8'h0F, 64'hAAAA_BBBB_CCCC_DDDD);
        do_store(0, 40'h100D, 8'h30, 64'h0000_5566_0000_0000);
        do_store(1, 40'h2000, 8'hFF, 64'h0123_4567_89AB_CDEF);
        do_load(0, 40'h1000, 2'd3, "R7");   // youngest covers 4 of 8 bytes
        do_load(0, 40'h1000, 2'd2, "R6");   // youngest wins over older full store
        do_load(0, 40'h1004, 2'd2, "R9");   // upper lanes from older store
        do_load(0, 40'h1008, 2'd1, "R9");   // lanes 0-1, no overlap
        do_load(0, 40'h100C, 2'd0, "R5");   // lane 4 hit
        do_load(0, 40'h100C, 2'd2, "R7");   // lanes 4-7 partial
        do_load(1, 40'h1000, 2'd3, "R8");   // other thread's store
        do_load(0, 40'h2000, 2'd3, "R8");
        do_load(1, 40'h2000, 2'd3, "R5");
        // fill thread 2 and overflow it
        for (int i = 0; i < 9; i++) do_store(2, 40'h3000 + 40'(8*i), 8'hFF, 64'(i + 100));
        @(negedge clk);
        chk(thr_full == 4'b0100, "R2", "only thread 2 full", 64'(thr_full), 64'h4);
        tick();
        do_store(3, 40'h4000, 8'h01, 64'h77);
        // hold, then drain with an irregular acknowledge
        repeat (3) tick();
        dr_tag = "R4";
        for (int k = 0; k < 60; k++) begin
            drn_ack = (k % 3 != 0);
            tick();
        end
        drn_ack = 1;
        for (int k = 0; k < 40; k++) tick();
        drn_ack = 0;
        @(negedge clk);
        chk(drn_valid == 0, "R3", "all drained", 64'(drn_valid), 0);
        tick();
        // mixed traffic: enqueue, acknowledge and lookup in the same cycles
        dr_tag = "R11";
        lf = 32'h1BADF00D;
        for (int k = 0; k < 1500; k++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            st_valid = lf[0] | lf[1];
            st_tid   = lf[3:2];
            st_addr  = 40'h1000 + 40'({lf[5:4], 3'b000});
            st_mask  = lf[13:6];
            st_data  = {lf, ~lf};
            ld_valid = lf[14];
            ld_tid   = lf[16:15];
            ld_size  = lf[20:19];
            ld_addr  = 40'h1000 + 40'({lf[18:17], 3'b000}) + 40'(lf[23:21] & ~(3'((1 << lf[20:19]) - 1)));
            ld_tag   = "R11";
            drn_ack  = lf[24] & (lf[25] | lf[26]);
            tick();
        end
        st_valid = 0; ld_valid = 0; drn_ack = 1;
        repeat (40) tick();
        drn_ack = 0;
        @(negedge clk);
        chk(drn_valid == 0, "R3", "final drain", 64'(drn_valid), 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule